// File: doc/BRIEF.md
# Write-Through Data Cache Store Path

This block handles core stores for a data cache set to write-through. Each store request arrives with an address, a data word and byte-lane enables. The tag lookup result for the same address, a hit flag and a way number, arrives alongside it. Every accepted store becomes one single-beat write on the memory bus.

A store that hits also writes the same bytes into the matching cache line and touches the set's replacement (LRU) history. The line's valid and dirty flags are left alone, and the block has no output that could change them. A store that misses writes memory only. It allocates no line and changes no replacement state.

The core sees the store finish only once the bus responds, whether the response is a success or an error. An error raises a machine-check pulse. When a hit's bus write fails, the cache copy already written is kept and is not withdrawn or invalidated. Only one store is in flight at a time.

Top module: `wt_store_ctrl`

## Requirements
- R1: After reset, `st_ready` is 1 and `bus_req`, `arr_we`, `lru_upd`, `st_done` and `mchk` are all 0.
- R2: A store is accepted on a clock edge where `st_valid` and `st_ready` are both 1. From the next cycle, `bus_req` is 1. It holds `bus_addr` equal to the store address with bits [1:0] forced to 0, plus `bus_be` and `bus_data`. All three stay stable until the edge on which `bus_ack` or `bus_err` is seen.
- R3: For an accepted hit, `arr_we` is 1 for exactly the one cycle after acceptance. In that cycle, `arr_way` is the lookup way, `arr_set` is address bits [10:4], `arr_word` is address bits [3:2], and `arr_data`/`arr_be` carry the store.
- R4: For an accepted hit, `lru_upd` pulses in the same cycle as `arr_we`, with `lru_way` and `lru_set` equal to the hit's way and set.
- R5: For an accepted miss, `arr_we` and `lru_upd` stay 0 for the whole store.
- R6: Take the edge where `bus_req` is 1 and `bus_ack` or `bus_err` is 1. In the cycle after it, `st_done` is 1 for one cycle, `bus_req` is 0 and `st_ready` is 1 again.
- R7: If that response includes `bus_err`, `mchk` pulses in the same cycle as `st_done`. No further array write occurs for the failed store.
- R8: While a store is outstanding, `st_ready` is 0. A request presented then causes no array write, no LRU update and no change of the bus fields.
- R9: When `bus_ack` and `bus_err` are both 1 on the same edge, the response counts as an error (`mchk` pulses).
- R10: `bus_ack` or `bus_err` arriving while no store is outstanding is ignored: `st_done` and `mchk` stay 0.
- R11: Byte lanes whose enable is 0 are driven as 0 on both `bus_data` and `arr_data`. Lane k is bits [8k+7:8k], enabled by be[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Byte-lane enables |
| lk_hit | input | 1 | Tag lookup hit for this store |
| lk_way | input | 1 | Way that hit |
| st_ready | output | 1 | Store can be accepted |
| st_done | output | 1 | Store finished (one-cycle pulse) |
| mchk | output | 1 | Machine-check pulse on bus error |
| arr_we | output | 1 | Cache data array write strobe |
| arr_way | output | 1 | Way written |
| arr_set | output | 7 | Set index written |
| arr_word | output | 2 | Word within the line |
| arr_data | output | 32 | Data to the array |
| arr_be | output | 4 | Byte enables to the array |
| lru_upd | output | 1 | Replacement history update strobe |
| lru_way | output | 1 | Way to mark most recent |
| lru_set | output | 7 | Set whose history is updated |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_data | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_ack | input | 1 | Bus write succeeded |
| bus_err | input | 1 | Bus write failed |

## Verification
The bench targets a hit whose bus write fails. A design that reverted or repeated the array write there, or that dropped the machine check, would show a second `arr_we` or a missing `mchk`. Misses are checked for stray array or LRU strobes, which a design that allocated on a miss would produce. A second request is presented while a store is outstanding; a design that accepted it would move `bus_addr` or fire another array write. Simultaneous ack and error, responses while idle, partial byte enables and unaligned addresses are also exercised. These catch a design that favoured ack over error, completed a phantom store, or leaked disabled lanes or address low bits onto the bus.

// File: rtl/wts_pkg.sv
package wts_pkg;

    typedef enum logic [0:0] {
        WTS_IDLE = 1'b0,
        WTS_BUS  = 1'b1
    } wts_state_e;

    typedef enum logic [1:0] {
        WTS_RSP_NONE = 2'd0,
        WTS_RSP_OK   = 2'd1,
        WTS_RSP_ERR  = 2'd2
    } wts_rsp_e;

    // Error takes precedence when both responses arrive together.
    function automatic wts_rsp_e wts_classify(input logic ack, input logic err);
        if (err)
            return WTS_RSP_ERR;
        else if (ack)
            return WTS_RSP_OK;
        else
            return WTS_RSP_NONE;
    endfunction

endpackage

// File: rtl/wts_ctrl.sv
module wts_ctrl
    import wts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic st_valid,
    input  logic bus_ack,
    input  logic bus_err,
    output logic st_ready,
    output logic accept,
    output logic busy,
    output logic st_done,
    output logic mchk
);

    wts_state_e state_q;
    wts_rsp_e   rsp;

    always_comb begin
        rsp      = wts_classify(bus_ack, bus_err);
        st_ready = (state_q == WTS_IDLE);
        busy     = (state_q == WTS_BUS);
        accept   = st_valid && (state_q == WTS_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WTS_IDLE;
            st_done <= 1'b0;
            mchk    <= 1'b0;
        end else begin
            st_done <= 1'b0;
            mchk    <= 1'b0;
            case (state_q)
                WTS_IDLE: if (accept) state_q <= WTS_BUS;
                WTS_BUS: begin
                    if (rsp != WTS_RSP_NONE) begin
                        st_done <= 1'b1;
                        mchk    <= (rsp == WTS_RSP_ERR);
                        state_q <= WTS_IDLE;
                    end
                end
                default: state_q <= WTS_IDLE;
            endcase
        end
    end

    // R10: a finish pulse only follows an outstanding store
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        st_done |-> $past(busy));

endmodule

// File: rtl/wts_bus_port.sv
module wts_bus_port #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8,
    parameter int BOFF = $clog2(BEW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           busy,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  data,
    input  logic [BEW-1:0] be,
    input  logic           bus_ack,
    input  logic           bus_err,
    output logic           bus_req,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_data,
    output logic [BEW-1:0] bus_be
);

    localparam logic [AW-1:0] ALIGN_MASK = ~(AW'((1 << BOFF) - 1));

    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic [BEW-1:0] be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (accept) begin
            addr_q <= addr & ALIGN_MASK;
            data_q <= data;
            be_q   <= be;
        end
    end

    always_comb begin
        bus_req  = busy;
        bus_addr = addr_q;
        bus_data = data_q;
        bus_be   = be_q;
    end

    // R2: the write is held unchanged until the bus answers
    assert_bus_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !bus_err) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be)));

endmodule

// File: rtl/wts_cache_port.sv
module wts_cache_port #(
    parameter int WAYW = 1,
    parameter int SETW = 7,
    parameter int WRDW = 2,
    parameter int DW   = 32,
    parameter int BEW  = DW / 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            hit,
    input  logic [WAYW-1:0] way,
    input  logic [SETW-1:0] set_idx,
    input  logic [WRDW-1:0] word_idx,
    input  logic [DW-1:0]   data,
    input  logic [BEW-1:0]  be,
    output logic            arr_we,
    output logic [WAYW-1:0] arr_way,
    output logic [SETW-1:0] arr_set,
    output logic [WRDW-1:0] arr_word,
    output logic [DW-1:0]   arr_data,
    output logic [BEW-1:0]  arr_be,
    output logic            lru_upd,
    output logic [WAYW-1:0] lru_way,
    output logic [SETW-1:0] lru_set
);

    logic take;
    assign take = accept && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_we  <= 1'b0;
            lru_upd <= 1'b0;
        end else begin
            arr_we  <= take;
            lru_upd <= take;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_way  <= '0;
            arr_set  <= '0;
            arr_word <= '0;
            arr_data <= '0;
            arr_be   <= '0;
            lru_way  <= '0;
            lru_set  <= '0;
        end else if (take) begin
            arr_way  <= way;
            arr_set  <= set_idx;
            arr_word <= word_idx;
            arr_data <= data;
            arr_be   <= be;
            lru_way  <= way;
            lru_set  <= set_idx;
        end
    end

    // R3: array write is a single-cycle strobe
    assert_arr_one_shot_R3: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we);

endmodule

// File: rtl/wt_store_ctrl.sv
module wt_store_ctrl
    import wts_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int WAYS  = 2,
    parameter int SETS  = 128,
    parameter int WORDS = 4,
    localparam int BEW  = DW / 8,
    localparam int BOFF = $clog2(BEW),
    localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SETW = $clog2(SETS),
    localparam int WRDW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [BEW-1:0]  st_be,
    input  logic            lk_hit,
    input  logic [WAYW-1:0] lk_way,
    output logic            st_ready,
    output logic            st_done,
    output logic            mchk,
    output logic            arr_we,
    output logic [WAYW-1:0] arr_way,
    output logic [SETW-1:0] arr_set,
    output logic [WRDW-1:0] arr_word,
    output logic [DW-1:0]   arr_data,
    output logic [BEW-1:0]  arr_be,
    output logic            lru_upd,
    output logic [WAYW-1:0] lru_way,
    output logic [SETW-1:0] lru_set,
    output logic            bus_req,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_data,
    output logic [BEW-1:0]  bus_be,
    input  logic            bus_ack,
    input  logic            bus_err
);

    logic          accept;
    logic          busy;
    logic [DW-1:0] masked;

    // R11: disabled byte lanes are zeroed once, shared by both write paths
    for (genvar k = 0; k < BEW; k++) begin : g_lane
        assign masked[8*k +: 8] = st_be[k] ? st_data[8*k +: 8] : 8'h00;
    end

    wts_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .st_ready (st_ready),
        .accept   (accept),
        .busy     (busy),
        .st_done  (st_done),
        .mchk     (mchk)
    );

    wts_bus_port #(.AW(AW), .DW(DW), .BEW(BEW), .BOFF(BOFF)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .busy     (busy),
        .addr     (st_addr),
        .data     (masked),
        .be       (st_be),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .bus_req  (bus_req),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .bus_be   (bus_be)
    );

    wts_cache_port #(.WAYW(WAYW), .SETW(SETW), .WRDW(WRDW), .DW(DW), .BEW(BEW)) u_cache (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .hit      (lk_hit),
        .way      (lk_way),
        .set_idx  (st_addr[BOFF+WRDW +: SETW]),
        .word_idx (st_addr[BOFF +: WRDW]),
        .data     (masked),
        .be       (st_be),
        .arr_we   (arr_we),
        .arr_way  (arr_way),
        .arr_set  (arr_set),
        .arr_word (arr_word),
        .arr_data (arr_data),
        .arr_be   (arr_be),
        .lru_upd  (lru_upd),
        .lru_way  (lru_way),
        .lru_set  (lru_set)
    );

    // R3: the cache copy is written only while its bus write is outstanding
    assert_arr_with_bus_R3: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> bus_req);

    // R4: history update accompanies the array write on the same way and set
    assert_lru_with_arr_R4: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (lru_upd && lru_way == arr_way && lru_set == arr_set));

    // R6: finish pulse coincides with the bus request having dropped
    assert_done_releases_R6: assert property (@(posedge clk) disable iff (rst)
        st_done |-> (!bus_req && st_ready));

    // R7: machine check only together with a finish
    assert_mchk_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        mchk |-> st_done);

    // R8: no acceptance while a write is outstanding
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !st_ready);

endmodule

// File: tb/sim_wt_store_ctrl.sv
`timescale 1ns/1ps
module sim_wt_store_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic [3:0]  st_be;
    logic        lk_hit;
    logic [0:0]  lk_way;
    logic        st_ready, st_done, mchk;
    logic        arr_we, lru_upd, bus_req;
    logic [0:0]  arr_way, lru_way;
    logic [6:0]  arr_set, lru_set;
    logic [1:0]  arr_word;
    logic [31:0] arr_data, bus_addr, bus_data;
    logic [3:0]  arr_be, bus_be;
    logic        bus_ack, bus_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wt_store_ctrl u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .lk_hit(lk_hit), .lk_way(lk_way), .st_ready(st_ready),
        .st_done(st_done), .mchk(mchk), .arr_we(arr_we), .arr_way(arr_way),
        .arr_set(arr_set), .arr_word(arr_word), .arr_data(arr_data), .arr_be(arr_be),
        .lru_upd(lru_upd), .lru_way(lru_way), .lru_set(lru_set), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    typedef struct packed {
        logic        hit;
        logic        way;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        ack;
        logic        err;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 32'h0000_0124, 32'hDEAD_BEEF, 4'hF, 1'b1, 1'b0, 4'd0},
        '{1'b0, 1'b0, 32'h1000_0040, 32'h1234_5678, 4'hF, 1'b1, 1'b0, 4'd2},
        '{1'b1, 1'b1, 32'h0000_07FF, 32'hA1B2_C3D4, 4'b0101, 1'b1, 1'b0, 4'd1},
        '{1'b1, 1'b1, 32'h0000_03A8, 32'h5555_AAAA, 4'hF, 1'b0, 1'b1, 4'd3},
        '{1'b0, 1'b1, 32'hFFFF_FFFE, 32'hCAFE_F00D, 4'b1000, 1'b0, 1'b1, 4'd0},
        '{1'b1, 1'b0, 32'h0000_0010, 32'h0BAD_CAFE, 4'b0011, 1'b1, 1'b1, 4'd1},
        '{1'b0, 1'b0, 32'h8000_0003, 32'h7777_1111, 4'b0110, 1'b1, 1'b1, 4'd2}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_lanes(input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? d[8*k +: 8] : 8'h00;
        return r;
    endfunction

    task automatic run_store(input vec_t v);
        logic [31:0] ea, ed;
        ea = {v.addr[31:2], 2'b00};
        ed = mask_lanes(v.data, v.be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = v.addr; st_data = v.data; st_be = v.be;
        lk_hit = v.hit; lk_way = v.way;
        @(negedge clk);
        st_valid = 1'b0;
        check(bus_req === 1'b1, "R2 bus_req", 64'(bus_req), 64'd1);
        check(bus_addr === ea, "R2 bus_addr", 64'(bus_addr), 64'(ea));
        check(bus_be === v.be, "R2 bus_be", 64'(bus_be), 64'(v.be));
        check(bus_data === ed, "R11 bus_data", 64'(bus_data), 64'(ed));
        check(st_ready === 1'b0, "R8 st_ready busy", 64'(st_ready), 64'd0);
        if (v.hit) begin
            check(arr_we === 1'b1, "R3 arr_we", 64'(arr_we), 64'd1);
            check(arr_way === v.way, "R3 arr_way", 64'(arr_way), 64'(v.way));
            check(arr_set === v.addr[10:4], "R3 arr_set", 64'(arr_set), 64'(v.addr[10:4]));
            check(arr_word === v.addr[3:2], "R3 arr_word", 64'(arr_word), 64'(v.addr[3:2]));
            check(arr_data === ed, "R11 arr_data", 64'(arr_data), 64'(ed));
            check(arr_be === v.be, "R3 arr_be", 64'(arr_be), 64'(v.be));
            check(lru_upd === 1'b1, "R4 lru_upd", 64'(lru_upd), 64'd1);
            check(lru_way === v.way && lru_set === v.addr[10:4], "R4 lru target",
                  64'({lru_way, lru_set}), 64'({v.way, v.addr[10:4]}));
        end else begin
            check(arr_we === 1'b0 && lru_upd === 1'b0, "R5 miss no cache strobe",
                  64'({arr_we, lru_upd}), 64'd0);
        end
        for (int i = 0; i < int'(v.lat); i++) begin
            @(negedge clk);
            check(arr_we === 1'b0 && lru_upd === 1'b0, "R3 R5 no repeat strobe",
                  64'({arr_we, lru_upd}), 64'd0);
            check(bus_req === 1'b1 && bus_addr === ea && bus_data === ed, "R2 hold",
                  64'(bus_addr), 64'(ea));
            check(st_done === 1'b0, "R6 no early done", 64'(st_done), 64'd0);
        end
        bus_ack = v.ack; bus_err = v.err;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0;
        check(st_done === 1'b1, "R6 st_done", 64'(st_done), 64'd1);
        check(bus_req === 1'b0 && st_ready === 1'b1, "R6 release",
              64'({bus_req, st_ready}), 64'd1);
        check(mchk === v.err, "R7 R9 mchk", 64'(mchk), 64'(v.err));
        check(arr_we === 1'b0, "R7 no array write on finish", 64'(arr_we), 64'd0);
        @(negedge clk);
        check(st_done === 1'b0 && mchk === 1'b0, "R6 single pulse", 64'({st_done, mchk}), 64'd0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
        lk_hit = 1'b0; lk_way = '0; bus_ack = 1'b0; bus_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(st_ready === 1'b1 && bus_req === 1'b0 && arr_we === 1'b0 && lru_upd === 1'b0
              && st_done === 1'b0 && mchk === 1'b0, "R1 reset state",
              64'({st_ready, bus_req, arr_we, lru_upd, st_done, mchk}), 64'h20);

        for (int n = 0; n < NV; n++) run_store(TBL[n]);

        // R10: stray responses while idle
        bus_ack = 1'b1; bus_err = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0;
        check(st_done === 1'b0 && mchk === 1'b0, "R10 idle response ignored",
              64'({st_done, mchk}), 64'd0);

        // R8: second request while a store is outstanding
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h0000_0200; st_data = 32'h1111_2222; st_be = 4'hF;
        lk_hit = 1'b0; lk_way = '0;
        @(negedge clk);
        st_addr = 32'h0000_0350; st_data = 32'h9999_8888; lk_hit = 1'b1; lk_way = 1'b1;
        @(negedge clk);
        check(arr_we === 1'b0 && lru_upd === 1'b0, "R8 busy request no strobe",
              64'({arr_we, lru_upd}), 64'd0);
        check(bus_addr === 32'h0000_0200 && bus_data === 32'h1111_2222, "R8 bus fields kept",
              64'(bus_addr), 64'h200);
        check(st_ready === 1'b0, "R8 not ready", 64'(st_ready), 64'd0);
        st_valid = 1'b0;
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check(st_done === 1'b1 && mchk === 1'b0, "R6 finish after busy test",
              64'({st_done, mchk}), 64'h2);
        @(negedge clk);
        check(bus_req === 1'b0 && arr_we === 1'b0, "R8 dropped request not taken",
              64'({bus_req, arr_we}), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule